// File: doc/BRIEF.md
# Committable Slot Frame Buffer

This block passes whole frames from a producer to a consumer through one data memory divided into equal slots. Each slot is large enough for one frame of the largest allowed length. The producer streams words into its current slot. It then either commits the frame, which hands the slot to the reader, or cancels it, which throws the words away. A receiver uses cancel when a frame's checksum turns out to be bad, so the reader only ever sees frames that were accepted.

The read side is a ready/valid stream that delivers one committed frame at a time, in commit order. The first word of each frame is a length field L, and the reader emits that word followed by L payload words. No boundary marker is stored: the per-slot valid flag tells the reader that a frame is present, and the length word tells it where the frame ends. Once the last word is taken, the slot is released and the reader moves on to the next slot.

Writer states: `W_EMPTY` (no words yet), `W_FILL` (a partial frame), `W_BLOCKED` (the target slot still holds an unread frame). Writer transitions: EMPTY→FILL on an accepted word; EMPTY/FILL→EMPTY on cancel, or on a commit when the next slot is free; EMPTY/FILL→BLOCKED on a commit when the next slot is occupied; BLOCKED→EMPTY when the target slot is released. Reader states: `R_WAIT`, `R_LEN` (length word offered), `R_BODY` (payload offered). Reader transitions: WAIT→LEN when the current slot is valid; LEN→WAIT on a handshake of a zero length; LEN→BODY on a handshake of a nonzero length; BODY→WAIT on the handshake of the last payload word.

Top module: `slot_frame_buffer`

## Requirements
- R1: After the synchronous active-high reset, wr_ready is 1, rd_valid is 0, every slot is empty, and both the write slot and the read slot are slot 0.
- R2: A word is accepted when wr_valid and wr_ready are both 1 and wr_cancel is 0. It is stored at the next word offset of the current write slot. A commit with wr_ready at 1 and at least one word in the frame (the word in the same cycle counts) marks the slot full and moves the write slot to the next index, wrapping modulo SLOT_COUNT.
- R3: rd_valid first goes high in the cycle after the second rising edge counted from the edge that samples the commit, provided the reader is idle on that slot.
- R4: wr_cancel has priority over wr_commit and wr_valid. It discards the partial frame and any word offered in the same cycle, and the same slot is filled again from offset 0.
- R5: Words offered after SLOT_WORDS words of the frame are ignored. The frame keeps its first SLOT_WORDS words.
- R6: wr_ready is 0 while the write slot holds an unread frame. Words, commits and cancels are ignored while it is 0. It returns to 1 one edge after the reader releases that slot.
- R7: The reader emits the length word L (word 0) and then words 1..L in order. rd_data and rd_valid hold while rd_ready is 0. After the last handshake the slot is released, and rd_valid is 0 for at least one cycle.
- R8: A length word greater than SLOT_WORDS-1 is treated as SLOT_WORDS-1.
- R9: A commit with no word in the frame is ignored.
- R10: Frames are delivered in commit order, one slot after another, modulo SLOT_COUNT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write word present |
| wr_data | input | DATA_W | Write word |
| wr_commit | input | 1 | Close the frame and hand it to the reader |
| wr_cancel | input | 1 | Discard the partial frame |
| wr_ready | output | 1 | Write side can take words |
| rd_valid | output | 1 | Read word present |
| rd_ready | input | 1 | Consumer takes the word |
| rd_data | output | DATA_W | Read word |

## Verification
A word takes effect at the edge that samples it. A commit makes the slot's flag visible after that edge, and the frame's length word appears on rd_valid/rd_data one edge later. A release by the reader lifts wr_ready one edge after the last handshake. The bench keeps a behavioural model that is updated at every rising edge from the inputs it drove. It compares wr_ready, rd_valid and rd_data against the model at each falling edge, so every latency above is checked in exactly the cycle the requirement names.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
    typedef enum logic [1:0] {
        W_EMPTY   = 2'd0,
        W_FILL    = 2'd1,
        W_BLOCKED = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        R_WAIT = 2'd0,
        R_LEN  = 2'd1,
        R_BODY = 2'd2
    } rd_state_e;
endpackage

// File: rtl/sfb_store.sv
module sfb_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/sfb_flags.sv
module sfb_flags #(
    parameter int SLOT_COUNT = 4,
    parameter int SLOT_W     = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  set_en,
    input  logic [SLOT_W-1:0]     set_idx,
    input  logic                  clr_en,
    input  logic [SLOT_W-1:0]     clr_idx,
    output logic [SLOT_COUNT-1:0] full
);
    for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                full[s] <= 1'b0;
            else if (set_en && set_idx == SLOT_W'(s))
                full[s] <= 1'b1;
            else if (clr_en && clr_idx == SLOT_W'(s))
                full[s] <= 1'b0;
        end
    end

    // R6: the writer only closes a slot that the reader has released
    assert_set_free_slot_R6: assert property (@(posedge clk) disable iff (rst)
        set_en |-> !full[set_idx]);

    // R2: writer and reader never act on the same slot in one cycle
    assert_no_slot_collision_R2: assert property (@(posedge clk) disable iff (rst)
        (set_en && clr_en) |-> (set_idx != clr_idx));

    // R7: the reader only releases a slot that holds a frame
    assert_clear_full_slot_R7: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> full[clr_idx]);
endmodule

// File: rtl/sfb_writer.sv
module sfb_writer
    import sfb_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SLOT_WORDS = 16,
    parameter int SLOT_COUNT = 4
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  wr_valid,
    input  logic [DATA_W-1:0]                     wr_data,
    input  logic                                  wr_commit,
    input  logic                                  wr_cancel,
    output logic                                  wr_ready,
    input  logic [SLOT_COUNT-1:0]                 slot_full,
    output logic                                  mem_we,
    output logic [$clog2(SLOT_WORDS)+$clog2(SLOT_COUNT)-1:0] mem_waddr,
    output logic [DATA_W-1:0]                     mem_wdata,
    output logic                                  set_en,
    output logic [$clog2(SLOT_COUNT)-1:0]         set_idx
);
    localparam int OFF_W  = $clog2(SLOT_WORDS);
    localparam int SLOT_W = $clog2(SLOT_COUNT);

    wr_state_e         state, state_n;
    logic [SLOT_W-1:0] wslot;
    logic [OFF_W:0]    woff;
    logic              room, take, close, next_busy;

    assign room      = woff < (OFF_W+1)'(SLOT_WORDS);
    assign take      = (state != W_BLOCKED) && wr_valid && !wr_cancel && room;
    assign close     = (state != W_BLOCKED) && !wr_cancel && wr_commit
                       && ((state == W_FILL) || take);
    assign next_busy = slot_full[wslot + SLOT_W'(1)];

    always_comb begin
        state_n = state;
        unique case (state)
            W_EMPTY, W_FILL: begin
                if (wr_cancel)
                    state_n = W_EMPTY;
                else if (close)
                    state_n = next_busy ? W_BLOCKED : W_EMPTY;
                else if (take)
                    state_n = W_FILL;
            end
            W_BLOCKED: begin
                if (!slot_full[wslot]) state_n = W_EMPTY;
            end
            default: state_n = W_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= W_EMPTY;
            wslot <= '0;
            woff  <= '0;
        end else begin
            state <= state_n;
            if (state != W_BLOCKED) begin
                if (wr_cancel) begin
                    woff <= '0;
                end else if (close) begin
                    woff  <= '0;
                    wslot <= wslot + SLOT_W'(1);
                end else if (take) begin
                    woff <= woff + (OFF_W+1)'(1);
                end
            end
        end
    end

    always_comb begin
        wr_ready  = (state != W_BLOCKED);
        mem_we    = take;
        mem_waddr = {wslot, woff[OFF_W-1:0]};
        mem_wdata = wr_data;
        set_en    = close;
        set_idx   = wslot;
    end

    // R5: the fill offset never passes the slot size
    assert_offset_bound_R5: assert property (@(posedge clk) disable iff (rst)
        woff <= (OFF_W+1)'(SLOT_WORDS));

    // R4: after a cancel the next accepted word lands at offset 0
    assert_cancel_rewinds_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_cancel && state != W_BLOCKED) |=> (woff == '0));
endmodule

// File: rtl/sfb_reader.sv
module sfb_reader
    import sfb_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SLOT_WORDS = 16,
    parameter int SLOT_COUNT = 4
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [SLOT_COUNT-1:0]                 slot_full,
    input  logic                                  rd_ready,
    output logic                                  rd_valid,
    output logic [$clog2(SLOT_WORDS)+$clog2(SLOT_COUNT)-1:0] mem_raddr,
    input  logic [DATA_W-1:0]                     mem_rdata,
    output logic                                  clr_en,
    output logic [$clog2(SLOT_COUNT)-1:0]         clr_idx
);
    localparam int OFF_W  = $clog2(SLOT_WORDS);
    localparam int SLOT_W = $clog2(SLOT_COUNT);
    localparam logic [DATA_W-1:0] LEN_MAX = DATA_W'(SLOT_WORDS - 1);

    rd_state_e         state, state_n;
    logic [SLOT_W-1:0] rslot;
    logic [OFF_W-1:0]  roff, remain, head_len;
    logic              fire, last;

    assign head_len = (mem_rdata > LEN_MAX) ? OFF_W'(SLOT_WORDS - 1)
                                            : mem_rdata[OFF_W-1:0];
    assign fire     = (state != R_WAIT) && rd_ready;
    assign last     = fire && (((state == R_LEN) && (head_len == '0))
                            || ((state == R_BODY) && (remain == OFF_W'(1))));

    always_comb begin
        state_n = state;
        unique case (state)
            R_WAIT: if (slot_full[rslot]) state_n = R_LEN;
            R_LEN:  if (fire) state_n = (head_len == '0) ? R_WAIT : R_BODY;
            R_BODY: if (last) state_n = R_WAIT;
            default: state_n = R_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= R_WAIT;
            rslot  <= '0;
            roff   <= '0;
            remain <= '0;
        end else begin
            state <= state_n;
            if (last) begin
                roff  <= '0;
                rslot <= rslot + SLOT_W'(1);
            end else if (fire) begin
                roff <= roff + OFF_W'(1);
                if (state == R_LEN) remain <= head_len;
                else                remain <= remain - OFF_W'(1);
            end
        end
    end

    always_comb begin
        rd_valid  = (state != R_WAIT);
        mem_raddr = {rslot, roff};
        clr_en    = last;
        clr_idx   = rslot;
    end

    // R7: after the final word the stream pauses for at least one cycle
    assert_gap_after_frame_R7: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> !rd_valid);
endmodule

// File: rtl/slot_frame_buffer.sv
module slot_frame_buffer #(
    parameter int DATA_W     = 8,
    parameter int SLOT_WORDS = 16,
    parameter int SLOT_COUNT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_commit,
    input  logic              wr_cancel,
    output logic              wr_ready,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data
);
    localparam int OFF_W  = $clog2(SLOT_WORDS);
    localparam int SLOT_W = $clog2(SLOT_COUNT);
    localparam int ADDR_W = OFF_W + SLOT_W;

    logic [SLOT_COUNT-1:0] slot_full;
    logic                  mem_we, set_en, clr_en;
    logic [ADDR_W-1:0]     mem_waddr, mem_raddr;
    logic [DATA_W-1:0]     mem_wdata;
    logic [SLOT_W-1:0]     set_idx, clr_idx;

    sfb_writer #(.DATA_W(DATA_W), .SLOT_WORDS(SLOT_WORDS), .SLOT_COUNT(SLOT_COUNT)) u_wr (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_commit(wr_commit), .wr_cancel(wr_cancel), .wr_ready(wr_ready),
        .slot_full(slot_full), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .set_en(set_en), .set_idx(set_idx)
    );

    sfb_reader #(.DATA_W(DATA_W), .SLOT_WORDS(SLOT_WORDS), .SLOT_COUNT(SLOT_COUNT)) u_rd (
        .clk(clk), .rst(rst), .slot_full(slot_full), .rd_ready(rd_ready),
        .rd_valid(rd_valid), .mem_raddr(mem_raddr), .mem_rdata(rd_data),
        .clr_en(clr_en), .clr_idx(clr_idx)
    );

    sfb_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(mem_raddr), .rdata(rd_data)
    );

    sfb_flags #(.SLOT_COUNT(SLOT_COUNT), .SLOT_W(SLOT_W)) u_flags (
        .clk(clk), .rst(rst), .set_en(set_en), .set_idx(set_idx),
        .clr_en(clr_en), .clr_idx(clr_idx), .full(slot_full)
    );

    // R6: memory is never written inside a slot that still holds a frame
    assert_write_free_slot_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !slot_full[mem_waddr[ADDR_W-1 -: SLOT_W]]);

    // R7: a stalled word stays on the port unchanged
    assert_hold_when_stalled_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: tb/sim_slot_frame_buffer.sv
module sim_slot_frame_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int SW = 16;
    localparam int SC = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_valid = 1'b0, wr_commit = 1'b0, wr_cancel = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic wr_ready, rd_valid, rd_ready;
    logic [DW-1:0] rd_data;

    int rd_mode = 1;
    logic rd_tog = 1'b0;
    assign rd_ready = (rd_mode == 1) || ((rd_mode == 2) && rd_tog);

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_frame_buffer #(.DATA_W(DW), .SLOT_WORDS(SW), .SLOT_COUNT(SC)) u0 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_commit(wr_commit), .wr_cancel(wr_cancel), .wr_ready(wr_ready),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
    );

    // behavioural reference
    int m_mem [SC*SW];
    bit m_full [SC];
    int m_wslot, m_woff, m_rslot, m_ridx, m_rlen;
    bit m_blocked, m_stream;
    int frames_out;

    int checks = 0, fails = 0, cycles = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always @(posedge clk) begin
        bit pre [SC];
        bit acc;
        int pre_woff;
        for (int s = 0; s < SC; s++) pre[s] = m_full[s];
        if (rst) begin
            for (int s = 0; s < SC; s++) m_full[s] = 1'b0;
            m_wslot = 0; m_woff = 0; m_rslot = 0; m_ridx = 0; m_rlen = 0;
            m_blocked = 1'b0; m_stream = 1'b0;
        end else begin
            if (!m_stream) begin
                if (pre[m_rslot]) begin m_stream = 1'b1; m_ridx = 0; end
            end else if (rd_ready) begin
                bit fin;
                fin = 1'b0;
                if (m_ridx == 0) begin
                    m_rlen = (m_mem[m_rslot*SW] > SW-1) ? SW-1 : m_mem[m_rslot*SW];
                    if (m_rlen == 0) fin = 1'b1; else m_ridx = 1;
                end else if (m_ridx == m_rlen) fin = 1'b1;
                else m_ridx++;
                if (fin) begin
                    m_full[m_rslot] = 1'b0;
                    m_rslot = (m_rslot + 1) % SC;
                    m_stream = 1'b0; m_ridx = 0;
                    frames_out++;
                end
            end
            if (m_blocked) begin
                if (!pre[m_wslot]) m_blocked = 1'b0;
            end else if (wr_cancel) begin
                m_woff = 0;
            end else begin
                pre_woff = m_woff;
                acc = wr_valid && (m_woff < SW);
                if (acc) begin m_mem[m_wslot*SW + m_woff] = int'(wr_data); m_woff++; end
                if (wr_commit && (pre_woff > 0 || acc)) begin
                    m_full[m_wslot] = 1'b1;
                    m_blocked = pre[(m_wslot + 1) % SC];
                    m_wslot = (m_wslot + 1) % SC;
                    m_woff = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        rd_tog <= ~rd_tog;
        if (!rst && !done) begin
            checks++;
            if (wr_ready !== !m_blocked) begin
                fails++;
                $display("FAIL %s wr_ready got %0b exp %0b", cur_req, wr_ready, !m_blocked);
            end
            checks++;
            if (rd_valid !== m_stream) begin
                fails++;
                $display("FAIL %s rd_valid got %0b exp %0b", cur_req, rd_valid, m_stream);
            end
            if (m_stream) begin
                checks++;
                if (int'(rd_data) != m_mem[m_rslot*SW + m_ridx]) begin
                    fails++;
                    $display("FAIL %s rd_data got %0d exp %0d", cur_req, rd_data,
                             m_mem[m_rslot*SW + m_ridx]);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog expired got %0d cycles exp fewer", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic cyc(input bit v, input int d, input bit c, input bit x);
        @(negedge clk); #2;
        wr_valid = v; wr_data = DW'(d); wr_commit = c; wr_cancel = x;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
    endtask

    // length word len, then nw-1 payload words; commit on the last word
    task automatic frame(input int len, input int nw, input int seed);
        for (int i = 0; i < nw; i++)
            cyc(1, (i == 0) ? len : (seed + i) & 8'hff, i == nw - 1, 0);
    endtask

    initial begin
        for (int i = 0; i < SC*SW; i++) m_mem[i] = 0;
        frames_out = 0;
        idle(3);
        rst = 1'b0;
        cur_req = "R1"; idle(3);
        cur_req = "R2"; frame(3, 4, 16); idle(10);
        cur_req = "R7"; rd_mode = 2; frame(2, 3, 40); idle(12); rd_mode = 1;
        cur_req = "R9"; cyc(0, 0, 1, 0); idle(6);
        cur_req = "R3"; frame(1, 2, 60); idle(6);
        cur_req = "R10"; rd_mode = 2;
        frame(2, 3, 70); frame(0, 1, 0); frame(3, 4, 90); frame(1, 2, 110);
        idle(40); rd_mode = 1;
        cur_req = "R4";
        cyc(1, 5, 0, 0); cyc(1, 7, 0, 0); cyc(1, 9, 0, 1);
        frame(2, 3, 130); idle(8);
        cyc(1, 4, 0, 0); cyc(1, 3, 1, 1); frame(1, 2, 150); idle(8);
        cur_req = "R5";
        for (int i = 0; i < 20; i++) cyc(1, (i == 0) ? 15 : 160 + i, 0, 0);
        cyc(0, 0, 1, 0); idle(30);
        cur_req = "R8";
        for (int i = 0; i < SW; i++) cyc(1, (i == 0) ? 200 : 30 + i, i == SW - 1, 0);
        idle(30);
        cur_req = "R6"; rd_mode = 0;
        for (int f = 0; f < SC + 1; f++) frame(1, 2, 10 * f);
        cyc(0, 0, 0, 1); idle(5); rd_mode = 1; idle(30);
        frame(2, 3, 99); idle(20);
        cur_req = "R10";
        checks++;
        if (frames_out < 15) begin
            fails++;
            $display("FAIL R10 frames delivered got %0d exp at least 15", frames_out);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule